// File: doc/BRIEF.md
# Optical Packet Deframer

This block parses the receive side of a two-wavelength optical link. An upstream boundary detector flags the frame-open and frame-close markers. Between them the block takes one data bit per bit strobe from the state line. It sees a frame as an 11-bit identifier, a 4-bit byte-count code, a payload of 1 to 16 bytes and an 8-bit check value. It keeps the identifier, the count code and the payload in registers that a host can read. It also raises sticky flags for a completed frame, a check-value mismatch, a disagreement between the two wavelengths, and a frame that was closed too early.

The host can issue two separate clears. The buffer clear empties the payload buffer and the identifier register. The parser clear returns the field sequencer to idle and drops every flag. A host can therefore keep old captured data while it rearms the parser, or wipe the data without disturbing flags it has not yet read.

Top module: `optical_deframer`

## Requirements
- R1: After reset, rx_id, rx_len, rx_data and all four flags are zero.
- R2: After a frame-open event, the first 11 sampled bits form rx_id, most significant bit first.
- R3: The next 4 bits form rx_len, MSB first. The code gives the payload size in bytes, and code 0 means 16 bytes.
- R4: Payload bytes arrive MSB first. They are packed from rx_data bit 127 downward, and bits beyond the payload keep their previous value.
- R5: A CRC-8 (polynomial 0x07, initial value 0, MSB-first) is computed over the identifier, count and payload bits. When the 8th received check bit disagrees with it, crc_err is set. A matching check value leaves crc_err clear. crc_err stays set until the parser clear.
- R6: If match_bit is low on any bit sampled inside a frame, false_sig_err is set. That bit is still used as data, and the flag stays set until the parser clear.
- R7: A frame-close event after all 8 check bits sets frame_done. frame_done stays set until the parser clear, including while later frames are parsed.
- R8: A frame-close event before the 8th check bit sets framing_err, leaves frame_done unchanged and returns the parser to idle.
- R9: While idle, sampled bits and frame-close events change no output.
- R10: buf_clr zeroes rx_data and rx_id on the next edge. rx_len and the flags are not affected.
- R11: common_clr clears all four flags and returns the parser to idle. rx_id, rx_len and rx_data are kept.
- R12: A frame-open event while a frame is in progress restarts parsing at the identifier field and restarts the check computation.
- R13: start_det, stop_det and state_bit act only in cycles where bit_en is high. A frame-open event takes priority over a frame-close event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-slot strobe; qualifies all link inputs |
| start_det | input | 1 | Frame-open marker seen in this bit slot |
| stop_det | input | 1 | Frame-close marker seen in this bit slot |
| state_bit | input | 1 | Data value from the reference wavelength |
| match_bit | input | 1 | High when both wavelengths agree |
| buf_clr | input | 1 | Clear payload buffer and identifier |
| common_clr | input | 1 | Reset parser and flags |
| rx_id | output | 11 | Received identifier |
| rx_len | output | 4 | Received byte-count code |
| rx_data | output | 128 | Payload buffer, first byte in bits 127:120 |
| frame_done | output | 1 | Sticky: a complete frame was closed |
| crc_err | output | 1 | Sticky: check value mismatch |
| false_sig_err | output | 1 | Sticky: wavelength disagreement in frame |
| framing_err | output | 1 | Sticky: frame closed before check field ended |

## Verification
A field counter that is off by one shifts every later field. The bit after the fault lands in the wrong register, so rx_id, rx_len or the payload alignment is wrong as soon as the frame is read. The check comparison also fails, so crc_err shows the fault at the 8th check bit at the latest. A sequencer stuck outside idle shows up one bit slot later: a stray bit with match low sets false_sig_err, or an early close fails to raise framing_err. Each scenario therefore compares the registers and flags at the slot after the event.

// File: rtl/deframer_pkg.sv
package deframer_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_IDENT,
    PS_COUNT,
    PS_PAYLOAD,
    PS_CHECK,
    PS_TAIL
  } parse_state_e;
endpackage

// File: rtl/deframer_crc.sv
module deframer_crc #(
  parameter int          CRC_W    = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic calc_en,
  input  logic rxc_en,
  input  logic bit_in,
  output logic last_mismatch
);
  logic [CRC_W-1:0] calc_q, calc_d;
  logic [CRC_W-1:0] rxc_q, rxc_d;
  logic             fb;

  assign fb = calc_q[CRC_W-1] ^ bit_in;

  always_comb begin
    calc_d = calc_q;
    rxc_d  = rxc_q;
    if (seed) begin
      calc_d = '0;
      rxc_d  = '0;
    end else begin
      if (calc_en) calc_d = {calc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      if (rxc_en)  rxc_d  = {rxc_q[CRC_W-2:0], bit_in};
    end
  end

  // the value the received field would hold if this bit is its last
  assign last_mismatch = ({rxc_q[CRC_W-2:0], bit_in} != calc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_q <= '0;
      rxc_q  <= '0;
    end else begin
      calc_q <= calc_d;
      rxc_q  <= rxc_d;
    end
  end
endmodule

// File: rtl/deframer_capture.sv
module deframer_capture #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 128,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic              id_en,
  input  logic              len_en,
  input  logic              data_en,
  input  logic [IDX_W-1:0]  data_idx,
  input  logic              bit_in,
  output logic [ID_W-1:0]   id_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [DATA_W-1:0] data_q
);
  logic [ID_W-1:0]   id_d;
  logic [LEN_W-1:0]  len_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    id_d   = id_q;
    len_d  = len_q;
    data_d = data_q;
    if (len_en) len_d = {len_q[LEN_W-2:0], bit_in};
    if (buf_clr) begin
      id_d   = '0;
      data_d = '0;
    end else begin
      if (id_en)   id_d = {id_q[ID_W-2:0], bit_in};
      if (data_en) data_d[data_idx] = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      len_q  <= '0;
      data_q <= '0;
    end else begin
      id_q   <= id_d;
      len_q  <= len_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/deframer_ctrl.sv
module deframer_ctrl
  import deframer_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 128,
  parameter int CRC_W  = 8,
  localparam int IDX_W     = $clog2(DATA_W),
  localparam int MAX_BYTES = DATA_W / 8,
  localparam int CNT_W     = $clog2((DATA_W > ID_W) ? DATA_W : ID_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             match_bit,
  input  logic             common_clr,
  input  logic [LEN_W-1:0] len_code,
  input  logic             chk_mismatch,
  output logic             seed,
  output logic             calc_en,
  output logic             rxc_en,
  output logic             id_en,
  output logic             len_en,
  output logic             data_en,
  output logic [IDX_W-1:0] data_idx,
  output logic             frame_done,
  output logic             crc_err,
  output logic             false_sig_err,
  output logic             framing_err
);
  parse_state_e     st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d, crce_d, fse_d, fre_d;
  logic [CNT_W-1:0] data_last;
  int               nbytes;

  always_comb begin
    nbytes    = (len_code == '0) ? MAX_BYTES : int'(len_code);
    data_last = CNT_W'(nbytes * 8 - 1);
    data_idx  = IDX_W'(DATA_W - 1 - int'(cnt_q));
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = frame_done;
    crce_d  = crc_err;
    fse_d   = false_sig_err;
    fre_d   = framing_err;
    seed    = 1'b0;
    calc_en = 1'b0;
    rxc_en  = 1'b0;
    id_en   = 1'b0;
    len_en  = 1'b0;
    data_en = 1'b0;
    if (common_clr) begin
      st_d   = PS_IDLE;
      cnt_d  = '0;
      done_d = 1'b0;
      crce_d = 1'b0;
      fse_d  = 1'b0;
      fre_d  = 1'b0;
      seed   = 1'b1;
    end else if (bit_en) begin
      if (start_det) begin
        st_d  = PS_IDENT;
        cnt_d = '0;
        seed  = 1'b1;
      end else if (stop_det) begin
        if (st_q == PS_TAIL) begin
          done_d = 1'b1;
          st_d   = PS_IDLE;
        end else if (st_q != PS_IDLE) begin
          fre_d = 1'b1;
          st_d  = PS_IDLE;
        end
        cnt_d = '0;
      end else if (st_q != PS_IDLE) begin
        if (!match_bit) fse_d = 1'b1;
        unique case (st_q)
          PS_IDENT: begin
            id_en   = 1'b1;
            calc_en = 1'b1;
            if (cnt_q == CNT_W'(ID_W - 1)) begin
              st_d  = PS_COUNT;
              cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
          PS_COUNT: begin
            len_en  = 1'b1;
            calc_en = 1'b1;
            if (cnt_q == CNT_W'(LEN_W - 1)) begin
              st_d  = PS_PAYLOAD;
              cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
          PS_PAYLOAD: begin
            data_en = 1'b1;
            calc_en = 1'b1;
            if (cnt_q == data_last) begin
              st_d  = PS_CHECK;
              cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
          PS_CHECK: begin
            rxc_en = 1'b1;
            if (cnt_q == CNT_W'(CRC_W - 1)) begin
              if (chk_mismatch) crce_d = 1'b1;
              st_d  = PS_TAIL;
              cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= PS_IDLE;
      cnt_q         <= '0;
      frame_done    <= 1'b0;
      crc_err       <= 1'b0;
      false_sig_err <= 1'b0;
      framing_err   <= 1'b0;
    end else begin
      st_q          <= st_d;
      cnt_q         <= cnt_d;
      frame_done    <= done_d;
      crc_err       <= crce_d;
      false_sig_err <= fse_d;
      framing_err   <= fre_d;
    end
  end
endmodule

// File: rtl/optical_deframer.sv
module optical_deframer #(
  parameter int ID_W     = 11,
  parameter int LEN_W    = 4,
  parameter int DATA_W   = 128,
  parameter int CRC_W    = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              state_bit,
  input  logic              match_bit,
  input  logic              buf_clr,
  input  logic              common_clr,
  output logic [ID_W-1:0]   rx_id,
  output logic [LEN_W-1:0]  rx_len,
  output logic [DATA_W-1:0] rx_data,
  output logic              frame_done,
  output logic              crc_err,
  output logic              false_sig_err,
  output logic              framing_err
);
  logic             seed, calc_en, rxc_en, id_en, len_en, data_en, mism;
  logic [IDX_W-1:0] data_idx;

  deframer_ctrl #(
    .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .CRC_W(CRC_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_det(start_det),
    .stop_det(stop_det), .match_bit(match_bit), .common_clr(common_clr),
    .len_code(rx_len), .chk_mismatch(mism), .seed(seed), .calc_en(calc_en),
    .rxc_en(rxc_en), .id_en(id_en), .len_en(len_en), .data_en(data_en),
    .data_idx(data_idx), .frame_done(frame_done), .crc_err(crc_err),
    .false_sig_err(false_sig_err), .framing_err(framing_err)
  );

  deframer_capture #(
    .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .id_en(id_en),
    .len_en(len_en), .data_en(data_en), .data_idx(data_idx),
    .bit_in(state_bit), .id_q(rx_id), .len_q(rx_len), .data_q(rx_data)
  );

  deframer_crc #(
    .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) u_crc (
    .clk(clk), .rst_n(rst_n), .seed(seed), .calc_en(calc_en),
    .rxc_en(rxc_en), .bit_in(state_bit), .last_mismatch(mism)
  );
endmodule

// File: rtl/deframer_chk.sv
module deframer_chk #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              stop_det,
  input logic              buf_clr,
  input logic              common_clr,
  input logic [ID_W-1:0]   rx_id,
  input logic [LEN_W-1:0]  rx_len,
  input logic [DATA_W-1:0] rx_data,
  input logic              frame_done,
  input logic              crc_err,
  input logic              false_sig_err,
  input logic              framing_err
);
  logic [3:0] flags;
  assign flags = {frame_done, crc_err, false_sig_err, framing_err};

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !common_clr) |=> frame_done);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(bit_en && stop_det));

  assert_fse_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (false_sig_err && !common_clr) |=> false_sig_err);

  assert_crc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !common_clr) |=> crc_err);

  assert_buf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> (rx_data == '0 && rx_id == '0));

  assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    common_clr |=> (flags == 4'b0000));

  assert_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !buf_clr && !common_clr) |=>
      ($stable(rx_data) && $stable(rx_id) && $stable(rx_len) && $stable(flags)));
endmodule

bind optical_deframer deframer_chk #(
  .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .stop_det(stop_det),
  .buf_clr(buf_clr), .common_clr(common_clr), .rx_id(rx_id),
  .rx_len(rx_len), .rx_data(rx_data), .frame_done(frame_done),
  .crc_err(crc_err), .false_sig_err(false_sig_err), .framing_err(framing_err)
);

// File: tb/optical_deframer_tb.sv
module optical_deframer_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bit_en, start_det, stop_det, state_bit, match_bit;
  logic         buf_clr, common_clr;
  logic [10:0]  rx_id;
  logic [3:0]   rx_len;
  logic [127:0] rx_data;
  logic         frame_done, crc_err, false_sig_err, framing_err;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [10:0]  exp_id;
  logic [3:0]   exp_len;
  logic [127:0] exp_data;

  always #2 clk = ~clk;

  optical_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_det(start_det),
    .stop_det(stop_det), .state_bit(state_bit), .match_bit(match_bit),
    .buf_clr(buf_clr), .common_clr(common_clr), .rx_id(rx_id),
    .rx_len(rx_len), .rx_data(rx_data), .frame_done(frame_done),
    .crc_err(crc_err), .false_sig_err(false_sig_err), .framing_err(framing_err)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
  endfunction

  task automatic send_bit(input logic s, input logic m);
    @(negedge clk);
    state_bit = s; match_bit = m; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; match_bit = 1'b1;
  endtask

  task automatic send_start();
    @(negedge clk); start_det = 1'b1; bit_en = 1'b1;
    @(negedge clk); start_det = 1'b0; bit_en = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_det = 1'b1; bit_en = 1'b1;
    @(negedge clk); stop_det = 1'b0; bit_en = 1'b0;
  endtask

  task automatic pulse_common();
    @(negedge clk); common_clr = 1'b1;
    @(negedge clk); common_clr = 1'b0;
  endtask

  task automatic pulse_buf();
    @(negedge clk); buf_clr = 1'b1;
    @(negedge clk); buf_clr = 1'b0;
    exp_id = '0; exp_data = '0;
  endtask

  // full frame with start, optional corrupted check and a mismatched bit
  task automatic send_frame(input logic [10:0] id, input logic [3:0] code,
                            input logic [127:0] pay, input bit bad_crc,
                            input int bad_pos, input bit do_stop);
    logic [7:0] c;
    int nb;
    int k;
    c = 8'h00; k = 0;
    nb = (code == 4'd0) ? 16 : int'(code);
    send_start();
    for (int i = 10; i >= 0; i--) begin
      c = crc_step(c, id[i]); send_bit(id[i], k != bad_pos); k++;
    end
    for (int i = 3; i >= 0; i--) begin
      c = crc_step(c, code[i]); send_bit(code[i], k != bad_pos); k++;
    end
    for (int i = 0; i < nb * 8; i++) begin
      c = crc_step(c, pay[127 - i]); send_bit(pay[127 - i], k != bad_pos); k++;
      exp_data[127 - i] = pay[127 - i];
    end
    if (bad_crc) c = ~c;
    for (int i = 7; i >= 0; i--) send_bit(c[i], 1'b1);
    if (do_stop) send_stop();
    exp_id = id; exp_len = code;
  endtask

  task automatic t_reset();
    chk("R1 rx_id", 128'(rx_id), 128'd0);
    chk("R1 rx_len", 128'(rx_len), 128'd0);
    chk("R1 rx_data", rx_data, 128'd0);
    chk("R1 flags", 128'({frame_done, crc_err, false_sig_err, framing_err}), 128'd0);
  endtask

  task automatic t_good_frame();
    send_frame(11'h5A3, 4'd3, {8'hA5, 8'h3C, 8'h0F, 104'd0}, 0, -1, 1);
    chk("R2 identifier", 128'(rx_id), 128'(11'h5A3));
    chk("R3 count code", 128'(rx_len), 128'd3);
    chk("R4 payload packing", rx_data, {8'hA5, 8'h3C, 8'h0F, 104'd0});
    chk("R5 crc_err clear on good check", 128'(crc_err), 128'd0);
    chk("R7 frame_done", 128'(frame_done), 128'd1);
  endtask

  task automatic t_done_sticky();
    send_start();
    send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
    chk("R7 frame_done held during new frame", 128'(frame_done), 128'd1);
  endtask

  task automatic t_buf_clear();
    pulse_buf();
    chk("R10 data zero", rx_data, 128'd0);
    chk("R10 id zero", 128'(rx_id), 128'd0);
    chk("R10 len kept", 128'(rx_len), 128'd3);
    chk("R10 done kept", 128'(frame_done), 128'd1);
  endtask

  task automatic t_common_clear();
    send_frame(11'h0F1, 4'd1, {8'h77, 120'd0}, 0, -1, 1);
    pulse_common();
    chk("R11 flags cleared", 128'({frame_done, crc_err, false_sig_err, framing_err}), 128'd0);
    chk("R11 id kept", 128'(rx_id), 128'(exp_id));
    chk("R11 data kept", rx_data, exp_data);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_stop();
    chk("R9 idle bits ignored fse", 128'(false_sig_err), 128'd0);
    chk("R9 idle stop ignored", 128'({frame_done, framing_err}), 128'd0);
    chk("R9 idle bits leave id", 128'(rx_id), 128'(exp_id));
  endtask

  task automatic t_full_length();
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[127 - 8*i -: 8] = 8'(i * 17 + 1);
    send_frame(11'h7FF, 4'd0, p, 0, -1, 1);
    chk("R3 code 0 gives 16 bytes", rx_data, p);
    chk("R3 code 0 check ok", 128'({frame_done, crc_err}), 128'b10);
    pulse_common();
  endtask

  task automatic t_bad_crc();
    send_frame(11'h2B4, 4'd2, {8'hC3, 8'h99, 112'd0}, 1, -1, 1);
    chk("R5 crc_err on bad check", 128'(crc_err), 128'd1);
    chk("R5 frame still done", 128'(frame_done), 128'd1);
    chk("R4 partial payload keeps rest", rx_data, exp_data);
    pulse_common();
  endtask

  task automatic t_false_signal();
    send_frame(11'h111, 4'd1, {8'hE1, 120'd0}, 0, 17, 1);
    chk("R6 false_sig_err", 128'(false_sig_err), 128'd1);
    chk("R6 bit still used", rx_data[127:120], 128'(8'hE1));
    chk("R6 check unaffected", 128'(crc_err), 128'd0);
    pulse_common();
  endtask

  task automatic t_early_stop();
    send_start();
    for (int i = 10; i >= 0; i--) send_bit(11'h123 >> i, 1'b1);
    exp_id = 11'h123;
    send_stop();
    chk("R8 framing_err", 128'(framing_err), 128'd1);
    chk("R8 no frame_done", 128'(frame_done), 128'd0);
    chk("R2 id taken before early close", 128'(rx_id), 128'(exp_id));
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    chk("R8 parser idle after early close", 128'({false_sig_err, rx_len}), 128'({1'b0, exp_len}));
    pulse_common();
    send_frame(11'h3C5, 4'd1, {8'h5A, 120'd0}, 0, -1, 0);
    send_bit(1'b0, 1'b1);
    send_stop();
    chk("R8 close after check field is valid", 128'({frame_done, framing_err}), 128'b10);
    pulse_common();
  endtask

  task automatic t_bit_enable();
    @(negedge clk); start_det = 1'b1;
    repeat (3) @(negedge clk);
    start_det = 1'b0;
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    chk("R13 ungated start ignored", 128'(false_sig_err), 128'd0);
    chk("R13 id unchanged", 128'(rx_id), 128'(exp_id));
    @(negedge clk); start_det = 1'b1; stop_det = 1'b1; bit_en = 1'b1;
    @(negedge clk); start_det = 1'b0; stop_det = 1'b0; bit_en = 1'b0;
    send_bit(1'b1, 1'b0);
    chk("R13 start wins over stop", 128'(false_sig_err), 128'd1);
    pulse_common();
  endtask

  task automatic t_restart();
    send_start();
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
    send_frame(11'h246, 4'd2, {8'h81, 8'h42, 112'd0}, 0, -1, 1);
    chk("R12 id after restart", 128'(rx_id), 128'(11'h246));
    chk("R12 check after restart", 128'({frame_done, crc_err, framing_err}), 128'b100);
    chk("R12 payload after restart", rx_data[127:112], 128'(16'h8142));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; start_det = 1'b0; stop_det = 1'b0;
    state_bit = 1'b0; match_bit = 1'b1; buf_clr = 1'b0; common_clr = 1'b0;
    exp_id = '0; exp_len = '0; exp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_frame();
    t_done_sticky();
    t_buf_clear();
    pulse_common();
    t_common_clear();
    t_full_length();
    t_bad_crc();
    t_false_signal();
    t_early_stop();
    t_bit_enable();
    t_restart();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule